// File: doc/BRIEF.md
# Leading-digit reduced signed-digit adder

This block is the add stage of one coordinate path (x or y) in a pipelined rotation engine that keeps its words in radix-2 signed-digit form. Each stage adds a shifted copy of the other coordinate to its own word. Because that copy is shifted right, its leading digit positions are always zero. The adder exploits this. The lower positions, where both operands carry digits, use a full two-operand signed-digit cell. The leading positions, where the shifted operand is absent, use a lighter cell that adds a single digit plus a transfer.

At the very top, a fold cell merges the transfer out of the next-to-top position with the leading digit of A. It re-expresses the top two digits so that no extra output digit is ever needed. The outgoing carry is absorbed, not emitted. Each digit is carried as a (plus, minus) bit pair. The digit sum is computed in one combinational pass, with no carry chain longer than one position, and it is registered once at the output.

The word length and the number of leading positions where B is absent are both parameters. The B port is narrower than A by that count.

Top module: `sd_lead_reduced_adder`

## Requirements
- R1: A digit is encoded as a bit pair whose value is plus minus minus: (0,0)=0, (1,0)=+1, (0,1)=-1. An input pair (1,1) reads as zero. No output digit is ever (1,1).
- R2: The S value for the inputs present at a rising clock edge appears on the outputs right after that edge. A new result is produced on every cycle.
- R3: While the synchronous active-high reset is sampled high, every output digit is cleared to zero, whatever the inputs are.
- R4: For N = N_DIGITS, whenever |A + B + cin| <= 3*2^(N-2), the value of S, taken as the sum over j of digit_j * 2^j, equals A + B + cin.
- R5: B supplies only the low N - ZERO_LEAD digit positions, B digit j weighing 2^j. The leading ZERO_LEAD positions of S are formed from A and incoming transfers alone.
- R6: The carry-in pair enters at weight 1 and may take the value -1, 0 or +1. A carry-in pair of (1,1) has no effect.
- R7: A transfer into the top position that would push the leading digit to magnitude 2 is folded into the top two digits, without any extra digit. For example, with B = 0, cin = 0 and A holding +1 only in its two leading digits, S has +1 in its two leading digits and zero elsewhere. The same case with -1 digits gives -1 in both leading digits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| a_pos | input | N_DIGITS | Plus bits of operand A digits |
| a_neg | input | N_DIGITS | Minus bits of operand A digits |
| b_pos | input | N_DIGITS-ZERO_LEAD | Plus bits of the shifted operand B (low positions) |
| b_neg | input | N_DIGITS-ZERO_LEAD | Minus bits of the shifted operand B (low positions) |
| cin_pos | input | 1 | Plus bit of the carry-in digit |
| cin_neg | input | 1 | Minus bit of the carry-in digit |
| s_pos | output | N_DIGITS | Plus bits of the registered sum digits |
| s_neg | output | N_DIGITS | Minus bits of the registered sum digits |

## Verification
On every cycle, the assertions check three things. The transfer entering each position never has the same nonzero sign as that position's interim digit. No output digit is ever (1,1). The registered sum, read as an integer, equals the integer sum of the previous cycle's inputs whenever that sum lies in the valid range. Reset clearing the outputs is also checked on every cycle. Only the bench's scenarios can show the exact digit pattern of the top-position fold, and that (1,1) input pairs on A and on the carry-in are harmless. The same holds for B's restriction to its low positions and for back-to-back streaming with a mid-stream reset.

// File: rtl/sdadd_pkg.sv
package sdadd_pkg;

  // One radix-2 signed digit as a (plus, minus) bit pair; value = pos - neg.
  typedef struct packed {
    logic pos;
    logic neg;
  } sdig_t;

  function automatic int sd_val(input sdig_t d);
    return (d.pos ? 1 : 0) - (d.neg ? 1 : 0);
  endfunction

  // True when the digit value is 0 or +1 (a (1,1) pair counts as zero).
  function automatic logic sd_nonneg(input sdig_t d);
    return !(d.neg && !d.pos);
  endfunction

  // Canonical encoding of -1, 0, +1; larger magnitudes saturate.
  function automatic sdig_t sd_from_int(input int v);
    sdig_t r;
    r.pos = (v > 0);
    r.neg = (v < 0);
    return r;
  endfunction

endpackage

// File: rtl/sd_full_cell.sv
module sd_full_cell
  import sdadd_pkg::*;
(
  input  sdig_t a,
  input  sdig_t b,
  input  logic  low_nonneg,
  output sdig_t w,
  output sdig_t t
);

  int psum;

  // Two-step rule: psum = 2*t + w. The choice for |psum| = 1 looks at the
  // sign of the next lower position, so that w and the incoming transfer
  // never share a nonzero sign.
  always_comb begin
    psum = sd_val(a) + sd_val(b);
    w = sd_from_int(0);
    t = sd_from_int(0);
    case (psum)
      2: begin
        t = sd_from_int(1);
      end
      -2: begin
        t = sd_from_int(-1);
      end
      1: begin
        if (low_nonneg) begin
          t = sd_from_int(1);
          w = sd_from_int(-1);
        end else begin
          w = sd_from_int(1);
        end
      end
      -1: begin
        if (low_nonneg) begin
          w = sd_from_int(-1);
        end else begin
          t = sd_from_int(-1);
          w = sd_from_int(1);
        end
      end
      default: begin
        w = sd_from_int(0);
        t = sd_from_int(0);
      end
    endcase
  end

endmodule

// File: rtl/sd_zero_cell.sv
module sd_zero_cell
  import sdadd_pkg::*;
(
  input  sdig_t a,
  input  logic  low_nonneg,
  output sdig_t w,
  output sdig_t t
);

  logic is_plus;
  logic is_minus;

  // Same split as the full cell with the second operand tied to zero,
  // reduced to a few gates: the digit either stays or moves up one place.
  always_comb begin
    is_plus  = a.pos & ~a.neg;
    is_minus = a.neg & ~a.pos;
    t.pos    = is_plus & low_nonneg;
    t.neg    = is_minus & ~low_nonneg;
    w.pos    = (is_plus | is_minus) & ~low_nonneg;
    w.neg    = (is_plus | is_minus) & low_nonneg;
  end

endmodule

// File: rtl/sd_top_fold.sv
module sd_top_fold
  import sdadd_pkg::*;
(
  input  sdig_t a_top,
  input  sdig_t t_in,
  input  sdig_t s_low,
  output sdig_t hi,
  output sdig_t lo
);

  int pair;

  // The leading position sees a_top + t_in in -2..2. Merged with the
  // finished digit below it, the pair weighs -5..5 units of 2^(N-2).
  // Inside the valid range it is -3..3, which two digits express, so
  // the outgoing carry is absorbed.
  always_comb begin
    pair = 2 * (sd_val(a_top) + sd_val(t_in)) + sd_val(s_low);
    if (pair >= 2) begin
      hi = sd_from_int(1);
      lo = sd_from_int(pair - 2);
    end else if (pair <= -2) begin
      hi = sd_from_int(-1);
      lo = sd_from_int(pair + 2);
    end else begin
      hi = sd_from_int(0);
      lo = sd_from_int(pair);
    end
  end

endmodule

// File: rtl/sd_lead_reduced_adder.sv
module sd_lead_reduced_adder
  import sdadd_pkg::*;
#(
  parameter int N_DIGITS  = 16,
  parameter int ZERO_LEAD = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_DIGITS-1:0]           a_pos,
  input  logic [N_DIGITS-1:0]           a_neg,
  input  logic [N_DIGITS-ZERO_LEAD-1:0] b_pos,
  input  logic [N_DIGITS-ZERO_LEAD-1:0] b_neg,
  input  logic                          cin_pos,
  input  logic                          cin_neg,
  output logic [N_DIGITS-1:0]           s_pos,
  output logic [N_DIGITS-1:0]           s_neg
);

  localparam int B_DIGITS = N_DIGITS - ZERO_LEAD;
  localparam int TOP      = N_DIGITS - 1;
  localparam longint SUM_LIMIT = 3 * (longint'(1) << (N_DIGITS - 2));

  sdig_t a_d   [0:TOP];
  sdig_t b_d   [0:B_DIGITS-1];
  sdig_t w_d   [0:TOP-1];
  sdig_t t_d   [0:TOP];
  sdig_t s_c   [0:TOP-1];
  sdig_t s_fin [0:TOP];
  logic  low_ok [0:TOP-1];
  sdig_t cin_d;
  sdig_t fold_hi;
  sdig_t fold_lo;

  logic [N_DIGITS-1:0] s_pos_n;
  logic [N_DIGITS-1:0] s_neg_n;

  assign cin_d.pos = cin_pos;
  assign cin_d.neg = cin_neg;
  assign t_d[0]    = sd_from_int(sd_val(cin_d));

  for (genvar j = 0; j <= TOP; j++) begin : g_a_unpack
    assign a_d[j].pos = a_pos[j];
    assign a_d[j].neg = a_neg[j];
  end

  for (genvar j = 0; j < B_DIGITS; j++) begin : g_b_unpack
    assign b_d[j].pos = b_pos[j];
    assign b_d[j].neg = b_neg[j];
  end

  // Lookahead sign of the next lower position, used to pick each transfer.
  for (genvar j = 0; j < TOP; j++) begin : g_low
    if (j == 0) begin : g_from_cin
      assign low_ok[j] = sd_nonneg(cin_d);
    end else if (j - 1 < B_DIGITS) begin : g_from_both
      assign low_ok[j] = sd_nonneg(a_d[j-1]) & sd_nonneg(b_d[j-1]);
    end else begin : g_from_a
      assign low_ok[j] = sd_nonneg(a_d[j-1]);
    end
  end

  // Positions 0..TOP-1: full cells where B exists, zero cells above it.
  for (genvar j = 0; j < TOP; j++) begin : g_pos
    if (j < B_DIGITS) begin : g_full
      sd_full_cell u_cell (
        .a          (a_d[j]),
        .b          (b_d[j]),
        .low_nonneg (low_ok[j]),
        .w          (w_d[j]),
        .t          (t_d[j+1])
      );
    end else begin : g_zero
      sd_zero_cell u_cell (
        .a          (a_d[j]),
        .low_nonneg (low_ok[j]),
        .w          (w_d[j]),
        .t          (t_d[j+1])
      );
    end

    assign s_c[j] = sd_from_int(sd_val(w_d[j]) + sd_val(t_d[j]));

    // R1: interim digit and incoming transfer never share a nonzero sign
    AST_NO_DOUBLE_SIGN: assert property (@(posedge clk) disable iff (rst)
      !((w_d[j].pos && t_d[j].pos) || (w_d[j].neg && t_d[j].neg))); // R1
  end

  sd_top_fold u_fold (
    .a_top (a_d[TOP]),
    .t_in  (t_d[TOP]),
    .s_low (s_c[TOP-1]),
    .hi    (fold_hi),
    .lo    (fold_lo)
  );

  for (genvar j = 0; j <= TOP; j++) begin : g_fin
    if (j == TOP) begin : g_hi
      assign s_fin[j] = fold_hi;
    end else if (j == TOP - 1) begin : g_lo
      assign s_fin[j] = fold_lo;
    end else begin : g_mid
      assign s_fin[j] = s_c[j];
    end
  end

  always_comb begin
    for (int j = 0; j <= TOP; j++) begin
      s_pos_n[j] = s_fin[j].pos;
      s_neg_n[j] = s_fin[j].neg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_pos <= '0;
      s_neg <= '0;
    end else begin
      s_pos <= s_pos_n;
      s_neg <= s_neg_n;
    end
  end

  // ---------------- assertions ----------------
  function automatic longint vec_val(input logic [N_DIGITS-1:0] p,
                                     input logic [N_DIGITS-1:0] n);
    longint acc;
    acc = 0;
    for (int j = N_DIGITS - 1; j >= 0; j--) begin
      acc = 2 * acc + (p[j] ? 64'sd1 : 64'sd0) - (n[j] ? 64'sd1 : 64'sd0);
    end
    return acc;
  endfunction

  longint in_sum;
  logic   in_range;
  logic   chk_armed;

  always_comb begin
    in_sum = vec_val(a_pos, a_neg)
           + vec_val({{ZERO_LEAD{1'b0}}, b_pos}, {{ZERO_LEAD{1'b0}}, b_neg})
           + longint'(sd_val(cin_d));
    in_range = (in_sum <= SUM_LIMIT) && (in_sum >= -SUM_LIMIT);
  end

  always_ff @(posedge clk) begin
    if (rst) chk_armed <= 1'b0;
    else     chk_armed <= 1'b1;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (s_pos == '0 && s_neg == '0)); // R3

  AST_CANON_OUT: assert property (@(posedge clk) disable iff (rst)
    (s_pos & s_neg) == '0); // R1

  AST_SUM_VALUE: assert property (@(posedge clk) disable iff (rst)
    (chk_armed && $past(in_range)) |-> (vec_val(s_pos, s_neg) == $past(in_sum))); // R4

endmodule

// File: tb/sd_lead_reduced_adder_test.sv
module sd_lead_reduced_adder_test;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 16;
  localparam int ZL = 6;
  localparam int NB = N - ZL;
  localparam longint LIM = 3 * (longint'(1) << (N - 2));

  logic          clk;
  logic          rst;
  logic [N-1:0]  a_pos, a_neg;
  logic [NB-1:0] b_pos, b_neg;
  logic          cin_pos, cin_neg;
  logic [N-1:0]  s_pos, s_neg;

  int n_checks;
  int n_errors;

  sd_lead_reduced_adder #(.N_DIGITS(N), .ZERO_LEAD(ZL)) uut (
    .clk     (clk),
    .rst     (rst),
    .a_pos   (a_pos),
    .a_neg   (a_neg),
    .b_pos   (b_pos),
    .b_neg   (b_neg),
    .cin_pos (cin_pos),
    .cin_neg (cin_neg),
    .s_pos   (s_pos),
    .s_neg   (s_neg)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic longint val_n(input logic [N-1:0] p, input logic [N-1:0] n);
    longint acc;
    acc = 0;
    for (int j = 0; j < N; j++) begin
      if (p[j] && !n[j]) acc += (longint'(1) << j);
      if (n[j] && !p[j]) acc -= (longint'(1) << j);
    end
    return acc;
  endfunction

  function automatic longint val_b(input logic [NB-1:0] p, input logic [NB-1:0] n);
    return val_n({{ZL{1'b0}}, p}, {{ZL{1'b0}}, n});
  endfunction

  function automatic longint val_c(input logic p, input logic n);
    return (p && !n) ? 64'sd1 : ((n && !p) ? -64'sd1 : 64'sd0);
  endfunction

  task automatic expect_sum(input longint exp, input string tag);
    n_checks++;
    if ((s_pos & s_neg) != '0) begin
      n_errors++;
      $display("FAIL %s R1 digit (1,1) on output: pos=%h neg=%h expected no overlap",
               tag, s_pos, s_neg);
    end
    n_checks++;
    if (val_n(s_pos, s_neg) != exp) begin
      n_errors++;
      $display("FAIL %s value: actual %0d expected %0d", tag, val_n(s_pos, s_neg), exp);
    end
  endtask

  task automatic expect_digits(input logic [N-1:0] ep, input logic [N-1:0] en,
                               input string tag);
    n_checks++;
    if (s_pos != ep || s_neg != en) begin
      n_errors++;
      $display("FAIL %s digits: actual pos=%h neg=%h expected pos=%h neg=%h",
               tag, s_pos, s_neg, ep, en);
    end
  endtask

  task automatic drive(input logic [N-1:0] ap, input logic [N-1:0] an,
                       input logic [NB-1:0] bp, input logic [NB-1:0] bn,
                       input logic cp, input logic cn);
    a_pos = ap; a_neg = an; b_pos = bp; b_neg = bn; cin_pos = cp; cin_neg = cn;
  endtask

  // Drive at a falling edge, the result is registered at the next rising edge
  // and sampled at the falling edge after it.
  task automatic apply_check(input logic [N-1:0] ap, input logic [N-1:0] an,
                             input logic [NB-1:0] bp, input logic [NB-1:0] bn,
                             input logic cp, input logic cn, input string tag);
    longint exp;
    @(negedge clk);
    drive(ap, an, bp, bn, cp, cn);
    exp = val_n(ap, an) + val_b(bp, bn) + val_c(cp, cn);
    @(negedge clk);
    expect_sum(exp, tag);
  endtask

  // A digits with no three adjacent equal nonzero digits.
  task automatic gen_a(output logic [N-1:0] p, output logic [N-1:0] n);
    int d, prev1, prev2;
    prev1 = 0; prev2 = 0; p = '0; n = '0;
    for (int j = 0; j < N; j++) begin
      d = int'($urandom_range(0, 2)) - 1;
      if (d != 0 && d == prev1 && d == prev2) d = 0;
      if (d > 0) p[j] = 1'b1;
      if (d < 0) n[j] = 1'b1;
      prev2 = prev1;
      prev1 = d;
    end
  endtask

  task automatic gen_b(output logic [NB-1:0] p, output logic [NB-1:0] n);
    int d;
    p = '0; n = '0;
    for (int j = 0; j < NB; j++) begin
      d = int'($urandom_range(0, 2)) - 1;
      if (d > 0) p[j] = 1'b1;
      if (d < 0) n[j] = 1'b1;
    end
  endtask

  task automatic gen_vec(output logic [N-1:0] ap, output logic [N-1:0] an,
                         output logic [NB-1:0] bp, output logic [NB-1:0] bn,
                         output logic cp, output logic cn);
    longint v;
    int c;
    gen_a(ap, an);
    gen_b(bp, bn);
    c = int'($urandom_range(0, 2)) - 1;
    cp = (c > 0);
    cn = (c < 0);
    v = val_n(ap, an) + val_b(bp, bn) + val_c(cp, cn);
    if (v > LIM || v < -LIM) begin
      ap[N-1] = 1'b0;
      an[N-1] = 1'b0;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst = 1'b1;
    drive('1, '0, '1, '0, 1'b1, 1'b0);
    @(negedge clk);
    @(negedge clk);
    expect_digits('0, '0, "R3 reset with live inputs");
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_basic;
    apply_check('0, '0, '0, '0, 1'b0, 1'b0, "R4 all zero");
    apply_check(N'(16'h0155), '0, '0, '0, 1'b0, 1'b0, "R4 A only positive");
    apply_check('0, N'(16'h0a52), '0, '0, 1'b0, 1'b0, "R4 A only negative");
    apply_check('0, '0, NB'(10'h2aa), NB'(10'h155), 1'b0, 1'b0, "R5 B only mixed");
    apply_check(N'(16'h0001), '0, '0, NB'(10'h3ff), 1'b0, 1'b0, "R5 B all minus plus A");
    apply_check(N'(16'h2480), N'(16'h0100), NB'(10'h3ff), '0, 1'b1, 1'b0,
                "R5 B in low digits only");
  endtask

  task automatic t_cin;
    apply_check(N'(16'h0003), '0, '0, '0, 1'b1, 1'b0, "R6 cin +1");
    apply_check(N'(16'h0003), '0, '0, '0, 1'b0, 1'b1, "R6 cin -1");
    apply_check('0, N'(16'h0001), '0, '0, 1'b0, 1'b1, "R6 cin -1 with A -1");
    apply_check(N'(16'h0005), '0, NB'(10'h001), '0, 1'b1, 1'b1, "R6 cin (1,1) is zero");
  endtask

  task automatic t_encoding;
    apply_check('1, '1, '1, '1, 1'b1, 1'b1, "R1 all (1,1) inputs read as zero");
    apply_check(N'(16'h00f3), N'(16'h0030), NB'(10'h00c), NB'(10'h004), 1'b0, 1'b0,
                "R1 mixed (1,1) pairs");
  endtask

  task automatic t_fold;
    logic [N-1:0] top2;
    top2 = '0;
    top2[N-1] = 1'b1;
    top2[N-2] = 1'b1;
    apply_check(top2, '0, '0, '0, 1'b0, 1'b0, "R7 positive fold value");
    expect_digits(top2, '0, "R7 positive fold digits");
    apply_check('0, top2, '0, '0, 1'b0, 1'b0, "R7 negative fold value");
    expect_digits('0, top2, "R7 negative fold digits");
    apply_check(top2, '0, NB'(10'h3ff), '0, 1'b1, 1'b0, "R7 fold with low carries");
  endtask

  task automatic t_random;
    logic [N-1:0] ap, an;
    logic [NB-1:0] bp, bn;
    logic cp, cn;
    for (int k = 0; k < 400; k++) begin
      gen_vec(ap, an, bp, bn, cp, cn);
      apply_check(ap, an, bp, bn, cp, cn, "R4 random constrained A");
    end
  endtask

  task automatic t_stream;
    logic [N-1:0] ap, an;
    logic [NB-1:0] bp, bn;
    logic cp, cn;
    longint prev;
    @(negedge clk);
    gen_vec(ap, an, bp, bn, cp, cn);
    drive(ap, an, bp, bn, cp, cn);
    prev = val_n(ap, an) + val_b(bp, bn) + val_c(cp, cn);
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      expect_sum(prev, "R2 back-to-back stream");
      gen_vec(ap, an, bp, bn, cp, cn);
      drive(ap, an, bp, bn, cp, cn);
      prev = val_n(ap, an) + val_b(bp, bn) + val_c(cp, cn);
    end
    rst = 1'b1;
    @(negedge clk);
    expect_digits('0, '0, "R3 reset mid stream");
    rst = 1'b0;
    @(negedge clk);
    expect_sum(prev, "R2 first result after reset");
  endtask

  initial begin
    n_checks = 0;
    n_errors = 0;
    rst = 1'b1;
    drive('0, '0, '0, '0, 1'b0, 1'b0);
    t_reset();
    t_basic();
    t_cin();
    t_encoding();
    t_fold();
    t_random();
    t_stream();
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule